// File: doc/BRIEF.md
# Scanline Event Scheduler with Refresh Stall

This block paces one video scanline in steps of two master clocks. It keeps a horizontal position counter and a free-running master clock counter. Both counters advance by 2 on every clock. From the horizontal position it decodes a set of timing events:

- a dot-clock enable once every 4 master clocks;
- a memory refresh event that stalls the CPU for 40 master clocks and charges it 5 CPU cycles;
- the start of the per-line transfers on visible lines;
- a one-time transfer initialisation on line 0;
- an end-of-line request, which the video side accepts.

The refresh and initialisation positions are not fixed. They are recomputed at the start of every line, and again at reset, from the low three bits of the master clock. Event positions therefore drift with the phase at which a line begins. The video side supplies the current scanline number and the line on which vertical blank starts. When it accepts the end of the line, the scanline input must already show the number of the line that is beginning.

Top module: `line_event_sched`

## Requirements
- R1: On each clock out of reset, `hpos` and `mclk` each grow by 2. Synchronous reset clears both to 0. The only exception is an accepted end of line, which returns `hpos` to 0 while `mclk` still grows by 2.
- R2: `dot_en` is high exactly when `hpos` is a multiple of 4.
- R3: `eol_req` is high whenever `hpos` >= 1360. If `eol_ack` is high in such a cycle, `hpos` is 0 in the next cycle. An `eol_ack` given while `hpos` < 1360 is ignored, and `hpos` keeps counting.
- R4: The refresh position of a line is 538 minus (`mclk` mod 8), where `mclk` is taken in the cycle that accepts the end of the previous line. After reset the phase is taken as 0, so the position is 538.
- R5: `refresh_evt` is high for the single cycle in which `hpos` equals the refresh position. `cpu_charge` reads 5 in that cycle and 0 in every other cycle.
- R6: `cpu_stall` goes high in the cycle after `refresh_evt` and stays high for exactly 20 consecutive cycles. The counters keep advancing throughout.
- R7: `xfer_init` fires once, at `hpos` = 12 + (`mclk` mod 8), using the same phase as R4. It fires only if two conditions hold: the scanline input read 0 when the line began (at reset or at end-of-line acceptance), and it still reads 0 at the event.
- R8: `xfer_start` fires at `hpos` = 1104, but only while `scanline` < `vblank_line`.
- R9: Reset clears the stall and sets the positions as if the phase were 0. The initialisation event of the first line is enabled only if `scanline` reads 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one scheduler step per edge |
| rst | input | 1 | Synchronous active-high reset |
| scanline | input | 9 | Current scanline number |
| vblank_line | input | 9 | First line of vertical blank |
| eol_ack | input | 1 | Video side accepts end of line |
| hpos | output | 12 | Horizontal position in master clocks |
| mclk | output | 32 | Master clock count |
| dot_en | output | 1 | Dot / interrupt-counter enable |
| eol_req | output | 1 | End of line may be accepted |
| refresh_evt | output | 1 | Memory refresh event pulse |
| cpu_charge | output | 3 | CPU cycles charged this step |
| cpu_stall | output | 1 | CPU held for the refresh window |
| xfer_start | output | 1 | Per-line transfer start pulse |
| xfer_init | output | 1 | Line-0 transfer initialisation pulse |

## Verification
The event outputs (`dot_en`, `eol_req`, `refresh_evt`, `cpu_charge`, `xfer_start`, `xfer_init`) are decoded from the registered position. Each is therefore due in the same cycle in which `hpos` shows the matching value.

Two results arrive one edge later:
- `cpu_stall` rises one edge after `refresh_evt` and is due for exactly 20 cycles.
- An accepted end of line shows up as `hpos` = 0 one edge after the acknowledge.

The bench drives inputs on the falling edge and samples 1 ns later. It advances its own position and clock model by one step per cycle, so every sample is compared with the value predicted for that exact cycle. The refresh and initialisation positions are predicted from the model's clock phase at each acceptance.

// File: rtl/lsched_pkg.sv
`timescale 1ns/1ps
package lsched_pkg;

    localparam int HPOS_W   = 12;
    localparam int MCLK_W   = 32;
    localparam int LINE_W   = 9;
    localparam int PHASE_W  = 3;
    localparam int CHARGE_W = 3;

    // Default scheduling constants, in master clocks.
    localparam int DEF_STEP         = 2;
    localparam int DEF_DOT_DIV      = 4;
    localparam int DEF_EOL_MIN      = 1360;
    localparam int DEF_REFRESH_BASE = 538;
    localparam int DEF_INIT_BASE    = 12;
    localparam int DEF_XFER_POS     = 1104;
    localparam int DEF_STALL_STEPS  = 20;
    localparam int DEF_CHARGE_CYC   = 5;

    typedef logic [HPOS_W-1:0]  hpos_t;
    typedef logic [PHASE_W-1:0] phase_t;

    // Event positions latched at the start of each line.
    typedef struct packed {
        hpos_t refresh_at;
        hpos_t init_at;
        logic  init_vld;
    } evt_pos_t;

    function automatic hpos_t pos_minus_phase(input int base, input phase_t ph);
        return hpos_t'(base) - hpos_t'(ph);
    endfunction

    function automatic hpos_t pos_plus_phase(input int base, input phase_t ph);
        return hpos_t'(base) + hpos_t'(ph);
    endfunction

endpackage

// File: rtl/lsched_counters.sv
`timescale 1ns/1ps
module lsched_counters
    import lsched_pkg::*;
#(
    parameter int STEP    = DEF_STEP,
    parameter int EOL_MIN = DEF_EOL_MIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eol_ack,
    output hpos_t             hpos,
    output logic [MCLK_W-1:0] mclk,
    output logic              eol_req,
    output logic              line_accept
);

    assign eol_req     = (hpos >= hpos_t'(EOL_MIN));
    assign line_accept = eol_req && eol_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos <= '0;
            mclk <= '0;
        end else begin
            mclk <= mclk + MCLK_W'(STEP);
            hpos <= line_accept ? '0 : hpos + hpos_t'(STEP);
        end
    end

    assert_mclk_step_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> mclk == $past(mclk) + MCLK_W'(STEP));

    assert_hpos_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(line_accept)) |-> hpos == $past(hpos) + hpos_t'(STEP));

    assert_line_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (eol_ack && hpos >= hpos_t'(EOL_MIN)) |=> hpos == '0);

endmodule

// File: rtl/lsched_positions.sv
`timescale 1ns/1ps
module lsched_positions
    import lsched_pkg::*;
#(
    parameter int REFRESH_BASE = DEF_REFRESH_BASE,
    parameter int INIT_BASE    = DEF_INIT_BASE
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     reload,
    input  phase_t   phase,
    input  logic     line_zero,
    output evt_pos_t pos
);

    phase_t   eff_phase;
    evt_pos_t pos_d;

    // Reset behaves like a line start at phase 0.
    assign eff_phase = rst ? '0 : phase;

    always_comb begin
        pos_d = pos;
        if (rst || reload) begin
            // Drop the previous line's positions before writing new ones.
            pos_d.init_vld   = 1'b0;
            pos_d.refresh_at = pos_minus_phase(REFRESH_BASE, eff_phase);
            pos_d.init_at    = pos_plus_phase(INIT_BASE, eff_phase);
            pos_d.init_vld   = line_zero;
        end
    end

    always_ff @(posedge clk) begin
        pos <= pos_d;
    end

    assert_refresh_reload_R4: assert property (@(posedge clk) disable iff (rst)
        reload |=> pos.refresh_at == hpos_t'(REFRESH_BASE) - hpos_t'($past(phase)));

    assert_init_reload_R7: assert property (@(posedge clk) disable iff (rst)
        reload |=> (pos.init_vld == $past(line_zero)) &&
                   (pos.init_at == hpos_t'(INIT_BASE) + hpos_t'($past(phase))));

    assert_hold_positions_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reload)) |-> $stable(pos));

endmodule

// File: rtl/lsched_stall.sv
`timescale 1ns/1ps
module lsched_stall
    import lsched_pkg::*;
#(
    parameter int STALL_STEPS = DEF_STALL_STEPS,
    parameter int CHARGE_CYC  = DEF_CHARGE_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trigger,
    output logic                cpu_stall,
    output logic [CHARGE_W-1:0] cpu_charge
);

    localparam int CNT_W = $clog2(STALL_STEPS + 1);
    localparam int RUN_W = CNT_W + 1;

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trigger) begin
            left_q <= CNT_W'(STALL_STEPS);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign cpu_stall  = (left_q != '0);
    assign cpu_charge = trigger ? CHARGE_W'(CHARGE_CYC) : '0;

    // Run-length monitor for the stall window.
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!cpu_stall) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_stall_follows_R6: assert property (@(posedge clk) disable iff (rst)
        trigger |=> cpu_stall);

    assert_stall_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_stall) |-> run_q == RUN_W'(STALL_STEPS));

    assert_stall_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(STALL_STEPS));

    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> $past(trigger));

endmodule

// File: rtl/line_event_sched.sv
`timescale 1ns/1ps
module line_event_sched
    import lsched_pkg::*;
#(
    parameter int STEP         = DEF_STEP,
    parameter int DOT_DIV      = DEF_DOT_DIV,
    parameter int EOL_MIN      = DEF_EOL_MIN,
    parameter int REFRESH_BASE = DEF_REFRESH_BASE,
    parameter int INIT_BASE    = DEF_INIT_BASE,
    parameter int XFER_POS     = DEF_XFER_POS,
    parameter int STALL_STEPS  = DEF_STALL_STEPS,
    parameter int CHARGE_CYC   = DEF_CHARGE_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_W-1:0]   scanline,
    input  logic [LINE_W-1:0]   vblank_line,
    input  logic                eol_ack,
    output logic [HPOS_W-1:0]   hpos,
    output logic [MCLK_W-1:0]   mclk,
    output logic                dot_en,
    output logic                eol_req,
    output logic                refresh_evt,
    output logic [CHARGE_W-1:0] cpu_charge,
    output logic                cpu_stall,
    output logic                xfer_start,
    output logic                xfer_init
);

    localparam int DOT_BITS = $clog2(DOT_DIV);

    logic     line_accept;
    logic     on_line_zero;
    evt_pos_t pos;

    assign on_line_zero = (scanline == '0);

    lsched_counters #(
        .STEP    (STEP),
        .EOL_MIN (EOL_MIN)
    ) u_counters (
        .clk         (clk),
        .rst         (rst),
        .eol_ack     (eol_ack),
        .hpos        (hpos),
        .mclk        (mclk),
        .eol_req     (eol_req),
        .line_accept (line_accept)
    );

    lsched_positions #(
        .REFRESH_BASE (REFRESH_BASE),
        .INIT_BASE    (INIT_BASE)
    ) u_positions (
        .clk       (clk),
        .rst       (rst),
        .reload    (line_accept),
        .phase     (mclk[PHASE_W-1:0]),
        .line_zero (on_line_zero),
        .pos       (pos)
    );

    lsched_stall #(
        .STALL_STEPS (STALL_STEPS),
        .CHARGE_CYC  (CHARGE_CYC)
    ) u_stall (
        .clk        (clk),
        .rst        (rst),
        .trigger    (refresh_evt),
        .cpu_stall  (cpu_stall),
        .cpu_charge (cpu_charge)
    );

    assign dot_en      = (hpos[DOT_BITS-1:0] == '0);
    assign refresh_evt = (hpos == pos.refresh_at);
    assign xfer_init   = pos.init_vld && on_line_zero && (hpos == pos.init_at);
    assign xfer_start  = (hpos == hpos_t'(XFER_POS)) && (scanline < vblank_line);

    assert_charge_alone_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_charge != '0) |=> (cpu_charge == '0));

    assert_init_line0_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_init |-> (scanline == '0) && !eol_req);

    assert_dot_alternates_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(line_accept) && DOT_DIV == 2 * STEP) |-> (dot_en != $past(dot_en)));

endmodule

// File: tb/line_event_sched_tb.sv
`timescale 1ns/1ps
module line_event_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  scanline = '0;
    logic [8:0]  vblank_line = 9'd225;
    logic        eol_ack = 1'b0;
    logic [11:0] hpos;
    logic [31:0] mclk;
    logic        dot_en, eol_req, refresh_evt, cpu_stall, xfer_start, xfer_init;
    logic [2:0]  cpu_charge;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the scheduler state.
    int exp_h, exp_m;
    int ref_pos, init_pos;
    bit init_on;

    always #2.5 clk = ~clk;

    line_event_sched dut_i (
        .clk (clk), .rst (rst), .scanline (scanline), .vblank_line (vblank_line),
        .eol_ack (eol_ack), .hpos (hpos), .mclk (mclk), .dot_en (dot_en),
        .eol_req (eol_req), .refresh_evt (refresh_evt), .cpu_charge (cpu_charge),
        .cpu_stall (cpu_stall), .xfer_start (xfer_start), .xfer_init (xfer_init)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int line);
        @(negedge clk);
        rst = 1'b1;
        eol_ack = 1'b0;
        scanline = line[8:0];
        repeat (3) @(negedge clk);
        #1;
        check(hpos == 0, "R1", "hpos in reset", hpos, 0);
        check(mclk == 0, "R1", "mclk in reset", mclk, 0);
        check(cpu_stall == 1'b0, "R9", "stall cleared by reset", cpu_stall, 0);
        check(cpu_charge == 0, "R5", "charge in reset", cpu_charge, 0);
        rst = 1'b0;
        exp_h    = 2;
        exp_m    = 2;
        ref_pos  = 538;
        init_pos = 12;
        init_on  = (line == 0);
    endtask

    // Run one full line; the end of line is acknowledged at ack_at.
    task automatic run_line(input int cur, input int nxt, input int ack_at, input string tag);
        int  e_ref  = ref_pos;
        int  e_init = (init_on && cur == 0) ? init_pos : -1;
        int  e_xfer = (cur < int'(vblank_line)) ? 1104 : -1;
        int  seen_ref = -1, seen_init = -1, seen_xfer = -1;
        int  n_ref = 0, n_init = 0, n_xfer = 0;
        int  stall_first = -1, stall_cnt = 0;
        int  bad_h = 0, bad_m = 0, bad_dot = 0, bad_eol = 0, bad_chg = 0;
        int  guard = 0;
        bit  done = 1'b0;
        while (!done && guard < 2000) begin
            guard++;
            @(negedge clk);
            // Early acknowledge at 1350 must be ignored (R3).
            eol_ack = (exp_h == ack_at) || (exp_h == 1350);
            scanline = (exp_h == ack_at) ? nxt[8:0] : cur[8:0];
            #1;
            if (int'(hpos) != exp_h) bad_h++;
            if (mclk != 32'(exp_m)) bad_m++;
            if (dot_en != (exp_h % 4 == 0)) bad_dot++;
            if (eol_req != (exp_h >= 1360)) bad_eol++;
            if (refresh_evt) begin
                n_ref++;
                seen_ref = exp_h;
                if (cpu_charge != 3'd5) bad_chg++;
            end else if (cpu_charge != 3'd0) bad_chg++;
            if (xfer_init)  begin n_init++; seen_init = exp_h; end
            if (xfer_start) begin n_xfer++; seen_xfer = exp_h; end
            if (cpu_stall) begin
                stall_cnt++;
                if (stall_first < 0) stall_first = exp_h;
            end
            if (exp_h == ack_at) begin
                done     = 1'b1;
                ref_pos  = 538 - (exp_m % 8);
                init_pos = 12 + (exp_m % 8);
                init_on  = (nxt == 0);
                exp_h    = 0;
            end else begin
                exp_h += 2;
            end
            exp_m += 2;
        end
        check(bad_h == 0 && done, "R1", {tag, " hpos track errors"}, bad_h, 0);
        check(bad_m == 0, "R1", {tag, " mclk track errors"}, bad_m, 0);
        check(bad_dot == 0, "R2", {tag, " dot enable errors"}, bad_dot, 0);
        check(bad_eol == 0, "R3", {tag, " eol_req errors"}, bad_eol, 0);
        check(seen_ref == e_ref && n_ref == 1, "R4", {tag, " refresh position"}, seen_ref, e_ref);
        check(bad_chg == 0, "R5", {tag, " charge errors"}, bad_chg, 0);
        check(stall_first == e_ref + 2, "R6", {tag, " stall start"}, stall_first, e_ref + 2);
        check(stall_cnt == 20, "R6", {tag, " stall length"}, stall_cnt, 20);
        check(seen_init == e_init && n_init == (e_init >= 0 ? 1 : 0), "R7",
              {tag, " init position"}, seen_init, e_init);
        check(seen_xfer == e_xfer && n_xfer == (e_xfer >= 0 ? 1 : 0), "R8",
              {tag, " transfer start position"}, seen_xfer, e_xfer);
    endtask

    // Reset arriving in the middle of a stall window (R9).
    task automatic reset_mid_stall();
        int guard = 0;
        while (!cpu_stall && guard < 2000) begin
            guard++;
            @(negedge clk);
            eol_ack = 1'b0;
            #1;
        end
        check(cpu_stall == 1'b1, "R6", "stall reached before reset", cpu_stall, 1);
        do_reset(3);
    endtask

    initial begin
        do_reset(0);
        run_line(0, 0, 1366, "line0 phase0");      // R9: 538 and 12 after reset
        run_line(0, 7, 1360, "line0 phase6");      // R4/R7: 532 and 18
        run_line(7, 240, 1362, "visible line");    // no init, transfer at 1104
        run_line(240, 3, 1360, "vblank line");     // R8: no transfer in vblank
        reset_mid_stall();                         // R9: reset with line 3
        run_line(3, 3, 1360, "after reset line3"); // R9: no init enabled
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule